// File: doc/BRIEF.md
# T1 Test Pattern Generator

This block produces serial stimulus for exercising a T1/DS1 span, one bit per clock cycle whenever `enable` is high. A mode code chosen at a restart selects a fixed repetitive word (all zeros, 1:7, 3-in-24), a free-running 2^20 pseudorandom stream, a quasi-random stream whose zero runs are capped at fourteen, or a multipattern mode. The multipattern mode walks through five patterns on its own, each for a programmable number of bits, with no reselection.

Alongside the serial bit the block drives a one-cycle marker that flags the first bit of every pattern period and of every pattern change. It also drives the code of the pattern that produced the bit now on the output. Line coding, framing insertion and the analog line side belong to other blocks.

Top module: `t1_patgen`

## Requirements
- R1: After reset `bit_out`, `start_mark` and `pat_idx` are all 0, and with no restart the block behaves as the all-zeros mode, with code 0 and period 8.
- R2: A cycle with `restart` high latches `pat_sel` and `seg_len` and reinitialises every counter and the LFSR. In the next cycle `bit_out` is 0, `start_mark` is 0 and `pat_idx` is the first pattern of the mode. `restart` has priority over `enable`. The `pat_sel` codes are: 0 zeros, 1 1:7, 2 3-in-24, 3 2^20 PRBS, 4 QRSS, 5 multipattern, 6 and 7 zeros.
- R3: In a cycle with `enable` low and `restart` low, nothing advances. `bit_out` and `pat_idx` hold their values and `start_mark` is 0 in the next cycle.
- R4: The zeros mode (codes 0, 6, 7) emits only 0 bits with `pat_idx` = 0, and marks every 8th bit starting with the first.
- R5: The 1:7 mode (`pat_idx` = 2) emits a 1 at positions that are 0 mod 8 and 0 elsewhere.
- R6: The 3-in-24 mode (`pat_idx` = 4) emits 1 at positions 0, 1 and 5 of each 24-bit period and 0 elsewhere.
- R7: The PRBS mode (`pat_idx` = 5) emits a sequence o with o[n+20] = o[n] XOR o[n+3] (polynomial x^20 + x^17 + 1). Its first 20 bits are the seed from bit 19 down to bit 0. It repeats every 1,048,575 bits.
- R8: The QRSS mode (`pat_idx` = 6) emits the R7 sequence, except that it emits a 1 whenever the 14 preceding output bits since restart are all 0. The LFSR keeps stepping either way, so the output never holds more than 14 zeros in a row.
- R9: Multipattern mode runs all ones (`pat_idx` 1), 1:7 (2), 2-in-8 with ones at positions 0 and 4 mod 8 (3), 3-in-24 (4), then QRSS (6), and wraps back to all ones. Each segment lasts `seg_len` bits, with 0 taken as 1. Each segment starts at position 0 with the LFSR reseeded.
- R10: `start_mark` is high for exactly the bits that start a period. That is position 0 of the fixed patterns, bit 0 mod 1,048,575 of the LFSR patterns, and the first bit of each multipattern segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Emit one bit this cycle |
| restart | input | 1 | Latch mode and segment length, reinitialise |
| pat_sel | input | 3 | Mode code, sampled at restart |
| seg_len | input | SEG_W | Multipattern segment length in bits, sampled at restart |
| bit_out | output | 1 | Serial test bit |
| start_mark | output | 1 | First bit of a period or segment |
| pat_idx | output | 3 | Code of the pattern that produced `bit_out` |

## Verification
The bench builds the block with the seed set to 1. This makes the LFSR start with nineteen zeros, so QRSS zero forcing appears within the first fifteen bits and again whenever a multipattern segment reseeds after the trailing zeros of 3-in-24. Segment lengths of 30 and 0 exercise a full multipattern cycle and its wrap within a few hundred clocks, as well as one-bit segments. The 1,048,575-bit period is beyond the run length, so only its start mark is observed.

// File: rtl/t1pg_pkg.sv
package t1pg_pkg;

    typedef enum logic [2:0] {
        PAT_ZEROS = 3'd0,
        PAT_ONES  = 3'd1,
        PAT_1IN8  = 3'd2,
        PAT_2IN8  = 3'd3,
        PAT_3IN24 = 3'd4,
        PAT_PRBS  = 3'd5,
        PAT_QRSS  = 3'd6
    } pat_e;

    localparam logic [2:0] SEL_MULTI = 3'd5;

    // first pattern emitted after a restart with the given mode code
    function automatic pat_e sel_first(input logic [2:0] sel);
        pat_e p;
        case (sel)
            3'd1:    p = PAT_1IN8;
            3'd2:    p = PAT_3IN24;
            3'd3:    p = PAT_PRBS;
            3'd4:    p = PAT_QRSS;
            3'd5:    p = PAT_ONES;
            default: p = PAT_ZEROS;
        endcase
        return p;
    endfunction

    // multipattern order: ones, 1:7, 2-in-8, 3-in-24, QRSS, wrap
    function automatic pat_e multi_next(input pat_e cur);
        pat_e p;
        case (cur)
            PAT_ONES:  p = PAT_1IN8;
            PAT_1IN8:  p = PAT_2IN8;
            PAT_2IN8:  p = PAT_3IN24;
            PAT_3IN24: p = PAT_QRSS;
            default:   p = PAT_ONES;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/t1pg_lfsr_step.sv
module t1pg_lfsr_step #(
    parameter int W   = 20,
    parameter int TAP = 17
) (
    input  logic [W-1:0] state,
    output logic [W-1:0] nxt,
    output logic         raw
);
    // Fibonacci form: oldest bit leaves at the top, new bit enters at the bottom
    assign raw = state[W-1];
    assign nxt = {state[W-2:0], state[W-1] ^ state[TAP-1]};
endmodule

// File: rtl/t1pg_fixed_pat.sv
module t1pg_fixed_pat
    import t1pg_pkg::*;
(
    input  pat_e       pat,
    input  logic [4:0] pos,
    output logic       bit_o,
    output logic       last
);
    always_comb begin
        bit_o = 1'b0;
        last  = 1'b1;
        case (pat)
            PAT_ZEROS: begin
                bit_o = 1'b0;
                last  = (pos == 5'd7);
            end
            PAT_ONES: begin
                bit_o = 1'b1;
                last  = (pos == 5'd7);
            end
            PAT_1IN8: begin
                bit_o = (pos == 5'd0);
                last  = (pos == 5'd7);
            end
            PAT_2IN8: begin
                bit_o = (pos == 5'd0) || (pos == 5'd4);
                last  = (pos == 5'd7);
            end
            PAT_3IN24: begin
                bit_o = (pos == 5'd0) || (pos == 5'd1) || (pos == 5'd5);
                last  = (pos == 5'd23);
            end
            default: begin
                bit_o = 1'b0;
                last  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/t1pg_zero_guard.sv
module t1pg_zero_guard #(
    parameter int ZMAX = 14,
    localparam int ZW  = $clog2(ZMAX + 1)
) (
    input  logic          raw,
    input  logic          active,
    input  logic [ZW-1:0] zrun,
    output logic          bit_o
);
    // a full run of ZMAX zeros turns the next raw zero into a one
    assign bit_o = raw | (active && (zrun == ZW'(ZMAX)));
endmodule

// File: rtl/t1_patgen.sv
module t1_patgen
    import t1pg_pkg::*;
#(
    parameter int                SEG_W    = 16,
    parameter int                LFSR_W   = 20,
    parameter int                LFSR_TAP = 17,
    parameter logic [LFSR_W-1:0] SEED     = LFSR_W'(1),
    parameter int                ZMAX     = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [2:0]       pat_sel,
    input  logic [SEG_W-1:0] seg_len,
    output logic             bit_out,
    output logic             start_mark,
    output logic [2:0]       pat_idx
);
    localparam int ZW = $clog2(ZMAX + 1);

    typedef struct packed {
        logic              multi;
        pat_e              cur;
        logic [4:0]        pos;
        logic [SEG_W-1:0]  seg_cnt;
        logic [SEG_W-1:0]  seg_len;
        logic [LFSR_W-1:0] lfsr;
        logic [ZW-1:0]     zrun;
        logic              bit_o;
        logic              mark;
        pat_e              idx;
    } st_t;

    st_t st_q, st_d;

    logic [LFSR_W-1:0] lfsr_nxt;
    logic              lfsr_raw;
    logic              fix_bit;
    logic              fix_last;
    logic              qrss_bit;

    t1pg_lfsr_step #(.W(LFSR_W), .TAP(LFSR_TAP)) u_lfsr (
        .state (st_q.lfsr),
        .nxt   (lfsr_nxt),
        .raw   (lfsr_raw)
    );

    t1pg_fixed_pat u_fixed (
        .pat   (st_q.cur),
        .pos   (st_q.pos),
        .bit_o (fix_bit),
        .last  (fix_last)
    );

    t1pg_zero_guard #(.ZMAX(ZMAX)) u_guard (
        .raw    (lfsr_raw),
        .active (st_q.cur == PAT_QRSS),
        .zrun   (st_q.zrun),
        .bit_o  (qrss_bit)
    );

    always_comb begin
        logic is_rand;
        logic nb;
        st_d      = st_q;
        st_d.mark = 1'b0;
        is_rand   = (st_q.cur == PAT_PRBS) || (st_q.cur == PAT_QRSS);
        nb        = is_rand ? qrss_bit : fix_bit;
        if (restart) begin
            st_d.multi   = (pat_sel == SEL_MULTI);
            st_d.cur     = sel_first(pat_sel);
            st_d.pos     = '0;
            st_d.seg_cnt = '0;
            st_d.seg_len = (seg_len == '0) ? SEG_W'(1) : seg_len;
            st_d.lfsr    = SEED;
            st_d.zrun    = '0;
            st_d.bit_o   = 1'b0;
            st_d.idx     = sel_first(pat_sel);
        end else if (enable) begin
            st_d.bit_o = nb;
            st_d.mark  = is_rand ? (st_q.lfsr == SEED) : (st_q.pos == 5'd0);
            st_d.idx   = st_q.cur;
            if (nb)
                st_d.zrun = '0;
            else if (st_q.zrun != ZW'(ZMAX))
                st_d.zrun = st_q.zrun + 1'b1;
            if (is_rand)
                st_d.lfsr = lfsr_nxt;
            st_d.pos = fix_last ? 5'd0 : st_q.pos + 5'd1;
            if (st_q.multi) begin
                if (st_q.seg_cnt == st_q.seg_len - 1'b1) begin
                    st_d.seg_cnt = '0;
                    st_d.cur     = multi_next(st_q.cur);
                    st_d.pos     = '0;
                    st_d.lfsr    = SEED;
                end else begin
                    st_d.seg_cnt = st_q.seg_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cur     <= PAT_ZEROS;
            st_q.idx     <= PAT_ZEROS;
            st_q.seg_len <= SEG_W'(1);
            st_q.lfsr    <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out    = st_q.bit_o;
    assign start_mark = st_q.mark;
    assign pat_idx    = st_q.idx;

endmodule

// File: rtl/t1_patgen_chk.sv
module t1_patgen_chk #(
    parameter int ZMAX = 14,
    localparam int ZC_W = $clog2(ZMAX + 2)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       restart,
    input logic       bit_out,
    input logic       start_mark,
    input logic [2:0] pat_idx
);
    logic            emit_q;
    logic            rs_q;
    logic [ZC_W-1:0] zc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            emit_q <= 1'b0;
            rs_q   <= 1'b0;
            zc     <= '0;
        end else begin
            emit_q <= enable && !restart;
            rs_q   <= restart;
            if (restart)
                zc <= '0;
            else if (emit_q)
                zc <= bit_out ? '0 : ((zc == ZC_W'(ZMAX + 1)) ? zc : zc + 1'b1);
        end
    end

    AST_QRSS_ZERO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_q && pat_idx == 3'd6 && !bit_out) |-> (zc < ZC_W'(ZMAX))); // R8

    AST_ZEROS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_q && pat_idx == 3'd0) |-> !bit_out); // R4

    AST_ONES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_q && pat_idx == 3'd1) |-> bit_out); // R9

    AST_MARK_NEEDS_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        start_mark |-> emit_q); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!emit_q && !rs_q) |-> ($stable(bit_out) && !start_mark)); // R3

    AST_1IN8_HEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_q && start_mark && pat_idx == 3'd2) |-> bit_out); // R5

    AST_3IN24_HEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_q && start_mark && pat_idx == 3'd4) |-> bit_out); // R6

    AST_SWITCH_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_q && pat_idx != $past(pat_idx)) |-> start_mark); // R9

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!bit_out && !start_mark)); // R2

endmodule

bind t1_patgen t1_patgen_chk #(.ZMAX(ZMAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .restart    (restart),
    .bit_out    (bit_out),
    .start_mark (start_mark),
    .pat_idx    (pat_idx)
);

// File: tb/t1_patgen_bench.sv
module t1_patgen_bench;
    localparam int          SEG_W  = 16;
    localparam logic [19:0] SEED_V = 20'h00001;
    localparam int          ZMAX_V = 14;
    localparam int          PERIOD = 1048575;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             restart = 1'b0;
    logic [2:0]       pat_sel = 3'd0;
    logic [SEG_W-1:0] seg_len = '0;
    logic             bit_out;
    logic             start_mark;
    logic [2:0]       pat_idx;

    always #10 clk = ~clk;

    t1_patgen #(.SEG_W(SEG_W), .SEED(SEED_V), .ZMAX(ZMAX_V)) u_t1_patgen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
        .pat_sel(pat_sel), .seg_len(seg_len),
        .bit_out(bit_out), .start_mark(start_mark), .pat_idx(pat_idx)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_multi;
    int m_cur;
    int m_n;
    int m_seg;
    int m_seglen;
    int m_zrun;
    bit hist[$];
    bit e_bit;
    bit e_mark;
    int e_idx;

    function automatic void reseed();
        hist.delete();
        for (int j = 19; j >= 0; j--) hist.push_back(SEED_V[j]);
    endfunction

    function automatic int first_of(input int sel);
        case (sel)
            1: return 2;
            2: return 4;
            3: return 5;
            4: return 6;
            5: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int after(input int p);
        case (p)
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 6;
            default: return 1;
        endcase
    endfunction

    function automatic void model_init();
        m_multi = 0; m_cur = 0; m_n = 0; m_seg = 0; m_seglen = 1; m_zrun = 0;
        e_bit = 0; e_mark = 0; e_idx = 0;
        reseed();
    endfunction

    function automatic void model_clock(input bit en, input bit rs, input int sel, input int sl);
        bit b;
        bit mk;
        bit nb;
        int r;
        if (rs) begin
            m_multi = (sel == 5);
            m_cur = first_of(sel);
            m_n = 0; m_seg = 0;
            m_seglen = (sl == 0) ? 1 : sl;
            m_zrun = 0;
            reseed();
            e_bit = 0; e_mark = 0; e_idx = m_cur;
        end else if (en) begin
            mk = ((m_n % 8) == 0);
            case (m_cur)
                0: b = 0;
                1: b = 1;
                2: b = ((m_n % 8) == 0);
                3: b = ((m_n % 8) == 0) || ((m_n % 8) == 4);
                4: begin
                    r = m_n % 24;
                    b = (r == 0) || (r == 1) || (r == 5);
                    mk = (r == 0);
                end
                default: begin
                    b = hist[0];
                    if (m_cur == 6 && m_zrun >= ZMAX_V) b = 1;
                    mk = ((m_n % PERIOD) == 0);
                    nb = hist[0] ^ hist[3];
                    void'(hist.pop_front());
                    hist.push_back(nb);
                end
            endcase
            m_zrun = b ? 0 : m_zrun + 1;
            e_bit = b; e_mark = mk; e_idx = m_cur;
            m_n++;
            if (m_multi) begin
                m_seg++;
                if (m_seg == m_seglen) begin
                    m_seg = 0;
                    m_cur = after(m_cur);
                    m_n = 0;
                    reseed();
                end
            end
        end else begin
            e_mark = 0;
        end
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (bit_out !== e_bit || start_mark !== e_mark || pat_idx !== 3'(e_idx)) begin
            errors++;
            $display("FAIL %s at %0t: bit/mark/idx got %0b/%0b/%0d expected %0b/%0b/%0d",
                     tag, $time, bit_out, start_mark, pat_idx, e_bit, e_mark, e_idx);
        end
    endtask

    // drive after a falling edge, model at the rising edge, compare at the next falling edge
    task automatic step(input bit en, input bit rs, input int sel, input int sl, input string tag);
        enable = en; restart = rs; pat_sel = 3'(sel); seg_len = SEG_W'(sl);
        @(posedge clk);
        model_clock(en, rs, sel, sl);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic run(input int n, input int gap, input string tag);
        for (int i = 0; i < n; i++) begin
            if (gap != 0 && (i % gap) == gap - 1)
                step(0, 0, 0, 0, tag);
            else
                step(1, 0, 0, 0, tag);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        model_init();
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");
        run(20, 0, "R1 R4 default zeros");

        step(1, 1, 1, 0, "R2 restart 1:7");
        run(40, 3, "R5 R10 R3 1:7 with idle gaps");

        step(0, 1, 2, 0, "R2 restart 3-in-24");
        run(60, 0, "R6 R10 3-in-24");

        step(1, 1, 3, 0, "R2 restart prbs");
        run(2000, 7, "R7 R3 prbs");

        step(1, 1, 4, 0, "R2 restart qrss");
        run(2000, 0, "R8 qrss");
        run(200, 5, "R8 R3 qrss idle gaps");

        step(1, 1, 5, 30, "R2 restart multi 30");
        run(330, 0, "R9 R10 multi seg 30");

        step(1, 1, 5, 0, "R2 restart multi 0");
        run(14, 0, "R9 multi seg 0");

        step(1, 1, 7, 0, "R2 restart code 7");
        run(20, 0, "R4 code 7 zeros");
        step(1, 1, 0, 0, "R2 restart code 0");
        run(20, 4, "R4 R3 code 0 zeros");

        step(1, 1, 2, 0, "R2 restart 3-in-24");
        run(10, 0, "R6 3-in-24 before cut");
        step(1, 1, 1, 0, "R2 restart mid-run");
        run(16, 0, "R5 after mid-run restart");

        finish_up();
    end
endmodule